// File: doc/BRIEF.md
# Dual-Channel Two-Slope Phase-Accumulator Waveform Generator

This block holds two independent waveform channels driven from one core clock. Each channel keeps a 48-bit phase word that grows on every clock. The amount added depends on which half of the cycle the phase is in. In the lower half (top bit clear) the channel adds its "low-half" step. In the upper half (top bit set) it adds its "high-half" step. Programming the two steps differently gives a waveform whose rising and falling segments have independent slopes.

A per-channel select register turns the upper 14 phase bits into a DAC code. The code can be a square, a rising ramp or a falling ramp, and it passes through one output register.

Control inputs can do three things:
- clear both phase words in the same cycle;
- add a programmed offset to one chosen channel, which moves that channel against the other;
- load all four step values at once, so no channel ever runs on a half-updated pair.

Top module: `dual_slope_dds`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both phase words, all step registers, both select registers and both DAC codes become zero. Select code 0 means rising ramp.
- R2: On a normal cycle, a channel whose phase bit 47 is 0 adds its stored low-half step, modulo 2^48.
- R3: On a normal cycle, a channel whose phase bit 47 is 1 adds its stored high-half step, modulo 2^48.
- R4: With select code 2'b00 (and also 2'b11), the DAC code is phase bits [47:34] unchanged.
- R5: With select code 2'b01, the DAC code is the bitwise inverse of phase bits [47:34].
- R6: With select code 2'b10, the DAC code is 14'h3FFF when phase bit 47 is 1 and 14'h0000 otherwise.
- R7: The DAC code after a clock edge is computed from the phase word and select code that were present before that edge, which gives one cycle of latency.
- R8: A high `step_load` replaces all four stored steps at the same edge, and the new steps are used from the next cycle on. While `step_load` is low, the step inputs have no effect.
- R9: A high `phase_clear` sets both phase words to zero at the next edge.
- R10: A high `offset_add` adds `offset_val` to the phase of the channel numbered `offset_ch` instead of its step for that cycle. The other channel steps normally.
- R11: When `phase_clear` and `offset_add` are both high, the clear wins and the offset is discarded.
- R12: A channel's select register loads from `wave_sel` only on an edge where `sel_load` is high. At other times changes on `wave_sel` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_load | input | 1 | Load all step values together |
| step_lo | input | 96 | Low-half steps, channel c at bits [48c+47:48c] |
| step_hi | input | 96 | High-half steps, channel c at bits [48c+47:48c] |
| sel_load | input | 1 | Load both select registers |
| wave_sel | input | 4 | Select codes, channel c at bits [2c+1:2c] |
| phase_clear | input | 1 | Clear both phase words |
| offset_add | input | 1 | Add offset to one channel's phase |
| offset_ch | input | 1 | Channel that receives the offset |
| offset_val | input | 48 | Offset value to add |
| dac_code | output | 28 | DAC codes, channel c at bits [14c+13:14c] |

## Verification
The bench runs four step/select patterns.
- Coarse power-of-two steps with a much steeper upper half show that the slope switches at the half-cycle boundary.
- Odd, non-aligned steps expose any carry error in the low bits that later ripples up into the code.
- A near-full-scale step shows wrap-around.
- A minus-one step makes the phase decrease within the lower half.

Each pattern pairs the two channels with different select codes, so a crossed channel, a swapped mux leg or a missing output register shows up as a code mismatch. Directed sequences then cover:
- loading new steps in the middle of a run, and changing the step inputs while the load is low;
- select changes with and without the load;
- an offset added to each channel in turn;
- an offset and a clear in the same cycle.

// File: rtl/dds_pkg.sv
// Shared definitions for the two-slope waveform generator.
// Assumes: select codes are 2 bits wide; the unused code behaves as a rising ramp.
package dds_pkg;
    typedef enum logic [1:0] {
        WAVE_RISE     = 2'b00,
        WAVE_FALL     = 2'b01,
        WAVE_SQUARE   = 2'b10,
        WAVE_RISE_ALT = 2'b11
    } wave_e;
endpackage

// File: rtl/dds_step_bank.sv
// Holds the low-half and high-half step values of every channel.
// Assumes: one load strobe updates all channels at the same edge, so
// no channel ever sees a mix of old and new steps.
module dds_step_bank #(
    parameter int NUM_CH  = 2,
    parameter int PHASE_W = 48,
    localparam int BUS_W  = NUM_CH * PHASE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BUS_W-1:0] lo_i,
    input  logic [BUS_W-1:0] hi_i,
    output logic [BUS_W-1:0] lo_o,
    output logic [BUS_W-1:0] hi_o
);
    // Capture all step values together on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o <= '0;
            hi_o <= '0;
        end else if (load_i) begin
            lo_o <= lo_i;
            hi_o <= hi_i;
        end
    end

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(lo_o) && $stable(hi_o))); // R8
    AST_STEP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (lo_o == $past(lo_i) && hi_o == $past(hi_i))); // R8
endmodule

// File: rtl/dds_phase_acc.sv
// One channel's phase accumulator. The step is chosen by the phase's top bit.
// Priority: clear, then offset add, then the normal step add.
// Assumes: the step inputs are already registered by the step bank.
module dds_phase_acc #(
    parameter int PHASE_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               offset_hit_i,
    input  logic [PHASE_W-1:0] offset_val_i,
    input  logic [PHASE_W-1:0] step_lo_i,
    input  logic [PHASE_W-1:0] step_hi_i,
    output logic [PHASE_W-1:0] phase_o
);
    logic [PHASE_W-1:0] step_sel;
    logic [PHASE_W-1:0] addend;

    // Choose the step by half-cycle, and let an offset replace it.
    always_comb begin
        step_sel = phase_o[PHASE_W-1] ? step_hi_i : step_lo_i;
        addend   = offset_hit_i ? offset_val_i : step_sel;
    end

    // Advance the phase word once per clock, or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) phase_o <= '0;
        else                   phase_o <= phase_o + addend;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (phase_o == '0)); // R11
    AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !offset_hit_i && !phase_o[PHASE_W-1])
        |=> (phase_o == $past(phase_o) + $past(step_lo_i))); // R2
    AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !offset_hit_i && phase_o[PHASE_W-1])
        |=> (phase_o == $past(phase_o) + $past(step_hi_i))); // R3
    AST_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && offset_hit_i)
        |=> (phase_o == $past(phase_o) + $past(offset_val_i))); // R10
endmodule

// File: rtl/dds_wave_out.sv
// Per-channel waveform select register and registered DAC code.
// Assumes: phase_top_i holds the top CODE_W phase bits; the code is
// formed from the select and phase values present before the edge.
module dds_wave_out
    import dds_pkg::*;
#(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we_i,
    input  logic [1:0]        sel_i,
    input  logic [CODE_W-1:0] phase_top_i,
    output logic [CODE_W-1:0] code_o
);
    wave_e             sel_q;
    logic [CODE_W-1:0] code_d;

    // Hold the selected waveform until the next select load.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= WAVE_RISE;
        else if (sel_we_i) sel_q <= wave_e'(sel_i);
    end

    // Map the phase bits to a code for the selected waveform.
    always_comb begin
        case (sel_q)
            WAVE_FALL:   code_d = ~phase_top_i;
            WAVE_SQUARE: code_d = {CODE_W{phase_top_i[CODE_W-1]}};
            default:     code_d = phase_top_i;
        endcase
    end

    // Register the code before it leaves the block.
    always_ff @(posedge clk) begin
        if (!rst_n) code_o <= '0;
        else        code_o <= code_d;
    end

    AST_RISE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == WAVE_RISE || sel_q == WAVE_RISE_ALT)
        |=> (code_o == $past(phase_top_i))); // R4
    AST_FALL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == WAVE_FALL) |=> (code_o == ~$past(phase_top_i))); // R5
    AST_SQUARE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == WAVE_SQUARE)
        |=> (code_o == {CODE_W{$past(phase_top_i[CODE_W-1])}})); // R6
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we_i |=> $stable(sel_q)); // R12
endmodule

// File: rtl/dual_slope_dds.sv
// Top of the dual-channel two-slope waveform generator.
// Each channel has a phase accumulator and a waveform output stage.
// All channels share one step bank, the clear command and the offset command.
// Assumes: every control input is synchronous to clk.
module dual_slope_dds #(
    parameter int NUM_CH  = 2,
    parameter int PHASE_W = 48,
    parameter int CODE_W  = 14,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_load,
    input  logic [NUM_CH*PHASE_W-1:0] step_lo,
    input  logic [NUM_CH*PHASE_W-1:0] step_hi,
    input  logic                      sel_load,
    input  logic [NUM_CH*2-1:0]       wave_sel,
    input  logic                      phase_clear,
    input  logic                      offset_add,
    input  logic [CH_W-1:0]           offset_ch,
    input  logic [PHASE_W-1:0]        offset_val,
    output logic [NUM_CH*CODE_W-1:0]  dac_code
);
    logic [NUM_CH*PHASE_W-1:0] lo_q;
    logic [NUM_CH*PHASE_W-1:0] hi_q;
    logic [NUM_CH*PHASE_W-1:0] phase_bus;

    dds_step_bank #(.NUM_CH(NUM_CH), .PHASE_W(PHASE_W)) u_steps (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (step_load),
        .lo_i   (step_lo),
        .hi_i   (step_hi),
        .lo_o   (lo_q),
        .hi_o   (hi_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        // Route the offset command to the channel it names.
        assign hit = offset_add && (offset_ch == CH_W'(c));

        dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
            .clk          (clk),
            .rst_n        (rst_n),
            .clear_i      (phase_clear),
            .offset_hit_i (hit),
            .offset_val_i (offset_val),
            .step_lo_i    (lo_q[c*PHASE_W +: PHASE_W]),
            .step_hi_i    (hi_q[c*PHASE_W +: PHASE_W]),
            .phase_o      (phase_bus[c*PHASE_W +: PHASE_W])
        );

        dds_wave_out #(.CODE_W(CODE_W)) u_out (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel_we_i    (sel_load),
            .sel_i       (wave_sel[c*2 +: 2]),
            .phase_top_i (phase_bus[c*PHASE_W + PHASE_W - CODE_W +: CODE_W]),
            .code_o      (dac_code[c*CODE_W +: CODE_W])
        );
    end
endmodule

// File: tb/tb_dual_slope_dds.sv
`timescale 1ns/1ps
module tb_dual_slope_dds;
    localparam int PW = 48;
    localparam int CW = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           step_load = 1'b0;
    logic [2*PW-1:0] step_lo = '0;
    logic [2*PW-1:0] step_hi = '0;
    logic           sel_load = 1'b0;
    logic [3:0]     wave_sel = '0;
    logic           phase_clear = 1'b0;
    logic           offset_add = 1'b0;
    logic [0:0]     offset_ch = '0;
    logic [PW-1:0]  offset_val = '0;
    logic [2*CW-1:0] dac_code;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    dual_slope_dds dut (
        .clk(clk), .rst_n(rst_n), .step_load(step_load), .step_lo(step_lo),
        .step_hi(step_hi), .sel_load(sel_load), .wave_sel(wave_sel),
        .phase_clear(phase_clear), .offset_add(offset_add),
        .offset_ch(offset_ch), .offset_val(offset_val), .dac_code(dac_code)
    );

    // Behavioural model written from the requirements.
    logic [PW-1:0] m_ph [2];
    logic [PW-1:0] m_lo [2];
    logic [PW-1:0] m_hi [2];
    logic [1:0]    m_sel [2];
    logic [CW-1:0] m_code [2];

    function automatic logic [CW-1:0] code_of(logic [1:0] s, logic [PW-1:0] p);
        case (s)
            2'b01:   return ~p[PW-1 -: CW];
            2'b10:   return p[PW-1] ? {CW{1'b1}} : {CW{1'b0}};
            default: return p[PW-1 -: CW];
        endcase
    endfunction

    task automatic model_edge();
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_ph[c] = '0; m_lo[c] = '0; m_hi[c] = '0; m_sel[c] = '0; m_code[c] = '0;
            end else begin
                m_code[c] = code_of(m_sel[c], m_ph[c]);
                if (phase_clear) m_ph[c] = '0;
                else if (offset_add && offset_ch == 1'(c)) m_ph[c] = m_ph[c] + offset_val;
                else m_ph[c] = m_ph[c] + (m_ph[c][PW-1] ? m_hi[c] : m_lo[c]);
                if (step_load) begin
                    m_lo[c] = step_lo[c*PW +: PW];
                    m_hi[c] = step_hi[c*PW +: PW];
                end
                if (sel_load) m_sel[c] = wave_sel[c*2 +: 2];
            end
        end
    endtask

    task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string sel_tag(logic [1:0] s);
        case (s)
            2'b01:   return "R5 fall R2 R3 R7";
            2'b10:   return "R6 square R2 R3 R7";
            default: return "R4 rise R2 R3 R7";
        endcase
    endfunction

    // Run n clock cycles, comparing both channels at each falling edge.
    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            for (int c = 0; c < 2; c++)
                check({tag, " / ", sel_tag(m_sel[c])}, dac_code[c*CW +: CW], m_code[c]);
        end
    endtask

    typedef struct packed {
        logic [PW-1:0] lo0, hi0, lo1, hi1;
        logic [1:0]    s0, s1;
        logic [7:0]    cyc;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{48'h0200_0000_0000, 48'h0800_0000_0000, 48'h0100_0000_0001, 48'h0400_0000_0003, 2'b00, 2'b01, 8'd120},
        '{48'h0123_4567_89AB, 48'h0FED_CBA9_8765, 48'h0800_0000_0000, 48'h0080_0000_0000, 2'b10, 2'b11, 8'd100},
        '{48'h0000_0400_0000, 48'h7000_0000_0000, 48'h0333_3333_3333, 48'h0055_5555_5555, 2'b01, 2'b10, 8'd100},
        '{48'hFFFF_FFFF_FFFF, 48'h1000_0000_0000, 48'h0400_0000_0000, 48'h0400_0000_0000, 2'b11, 2'b00, 8'd80}
    };

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        run(3, "R1 reset");
        check("R1 reset ch0", dac_code[CW-1:0], '0);
        check("R1 reset ch1", dac_code[2*CW-1:CW], '0);
        rst_n = 1'b1;
        run(3, "R1 zero steps after reset");

        // Table of step and select patterns.
        foreach (VECS[v]) begin
            step_lo = {VECS[v].lo1, VECS[v].lo0};
            step_hi = {VECS[v].hi1, VECS[v].hi0};
            wave_sel = {VECS[v].s1, VECS[v].s0};
            step_load = 1'b1; sel_load = 1'b1;
            run(1, "R8 R12 load");
            step_load = 1'b0; sel_load = 1'b0;
            run(int'(VECS[v].cyc), "table");
        end

        // R8: step inputs are ignored while the load is low.
        step_lo = {2{48'h7FFF_0000_0000}};
        step_hi = {2{48'h0000_0000_0001}};
        run(20, "R8 no load");
        step_load = 1'b1;
        run(1, "R8 load");
        step_load = 1'b0;
        run(20, "R8 new steps");

        // R12: the select input is ignored while sel_load is low.
        wave_sel = 4'b0110;
        run(10, "R12 no sel load");
        sel_load = 1'b1;
        run(1, "R12 sel load");
        sel_load = 1'b0;
        run(10, "R12 new sel");

        // R9: clear both phases; the code follows one cycle later (R7).
        phase_clear = 1'b1;
        run(1, "R9 clear");
        phase_clear = 1'b0;
        run(1, "R9 R7 after clear");
        run(5, "R9 resume");

        // R10: offset on each channel; the other channel steps normally.
        offset_add = 1'b1; offset_ch = 1'b1; offset_val = 48'h1234_5000_0000;
        run(1, "R10 offset ch1");
        offset_ch = 1'b0; offset_val = 48'h8000_0000_0000;
        run(1, "R10 offset ch0");
        offset_add = 1'b0;
        run(10, "R10 after offset");

        // R11: a clear beats an offset in the same cycle.
        phase_clear = 1'b1; offset_add = 1'b1; offset_ch = 1'b0; offset_val = 48'h4000_0000_0000;
        run(1, "R11 clear+offset");
        phase_clear = 1'b0; offset_add = 1'b0;
        run(1, "R11 after");
        check("R11 ch0 cleared", dac_code[CW-1:0], code_of(m_sel[0], '0));
        run(5, "R11 resume");

        // R1: a reset in the middle of a run returns everything to zero.
        rst_n = 1'b0;
        run(2, "R1 mid-run reset");
        check("R1 reset ch1", dac_code[2*CW-1:CW], '0);
        rst_n = 1'b1;
        run(3, "R1 after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule